// File: doc/BRIEF.md
# Cached-Row DRAM Cycle Controller

This block sits between a memory controller's strobe pins and a DRAM that has one SRAM row register acting as a single-line cache. Seven active-low or mode inputs are sampled on the system clock: row enable, column latch, write enable, refresh select, chip select, output enable and a write/read mode bit. Each time row enable falls, the block classifies the cycle and compares the row address with a stored last-read row. From that result it issues array commands (row fetch into the cache, array write, addressed refresh, counter refresh) and cache writes. It also gates the data output enable.

Hits and misses are decided only against the row held by the last read. A write to another row goes to the array alone. It leaves the cache and the stored row untouched and blanks the outputs until a programmable number of clocks after row enable returns high. The array is modelled as a command port with a single acknowledge, which reports that a row fetch has finished. Cycles that match no legal combination raise a sticky error flag and issue nothing.

Top module: `crdram_ctrl`

## Requirements
- R1: After reset, arr_cmd_o is 0, cache_wr_o and err_o are low, and with all strobes high dq_oe_o is low.
- R2: Strobes and address pass through a two-stage synchronizer. The command for a row-enable fall is registered on the third rising clock edge after the fall is presented and lasts one cycle.
- R3: A read (mode bit low, refresh high, chip select low, column latch high) whose full 11-bit row equals a valid stored row issues no array command.
- R4: A read whose row differs from the stored row, or made while no row is stored, issues code 1 (fetch) with that row and loads the stored row. dq_oe_o stays low after the fetch until arr_ack_i is seen high.
- R5: In a write hit (mode bit and refresh high, row equal to the stored row), each time column latch and write enable become low together, code 2 (array write) is issued with the latched row and column addr_i[8:0]. cache_wr_o is high in the same cycle.
- R6: In a write miss, code 2 is issued with the latched row and cache_wr_o stays low. The stored row shown on rd_row_o is unchanged.
- R7: A write-mode cycle in which column latch never goes low issues code 3 (addressed refresh) with the latched row when row enable rises. The stored row is unchanged.
- R8: In a write hit, dq_oe_o follows chip select and output enable while write enable is high. It is low while write enable is low.
- R9: For the whole of a write-miss cycle, and for blank_dly_i clocks after the rise of row enable is registered, dq_oe_o is low whatever output enable does.
- R10: Refresh select low at a row-enable fall issues code 4 (counter refresh) whatever the chip select level. arr_row_o carries an internal counter that starts at 0 after reset and steps by 1 on each such cycle. Cache reads stay allowed during the cycle.
- R11: With row enable high, chip select and output enable low drive dq_oe_o high. rd_row_o then shows the stored row and rd_col_o shows addr_i[8:0].
- R12: A row-enable fall with refresh high and chip select high, a read started with column latch low, or a write started with column latch or write enable low sets err_o. err_o stays set until reset, and no array command is issued for that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_en_ni | input | 1 | Row enable strobe, active low |
| col_lat_ni | input | 1 | Column latch strobe, active low |
| wr_en_ni | input | 1 | Write enable, active low |
| rfsh_ni | input | 1 | Counter refresh select, active low |
| sel_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| wr_mode_i | input | 1 | Cycle mode: 1 write, 0 read |
| addr_i | input | ROW_W (11) | Multiplexed row/column address |
| blank_dly_i | input | DLY_W (4) | Output blanking length after a write miss, in clocks |
| arr_ack_i | input | 1 | Array reports the row fetch is complete |
| arr_cmd_o | output | 3 | Array command: 0 none, 1 fetch, 2 write, 3 addressed refresh, 4 counter refresh |
| arr_row_o | output | ROW_W (11) | Row for the array command |
| arr_col_o | output | COL_W (9) | Column for an array or cache write |
| cache_wr_o | output | 1 | Write the cache at arr_col_o in step with the array |
| dq_oe_o | output | 1 | Data output enable, reads the cache |
| rd_row_o | output | ROW_W (11) | Stored row used for cache reads |
| rd_col_o | output | COL_W (9) | Column of the current cache read |
| err_o | output | 1 | Sticky illegal-cycle flag |

## Verification
A corrupted stored row shows up within three clocks as a spurious fetch on the next read of the old row, or as a changed rd_row_o after a write miss or an addressed refresh. A wrong cycle state is visible at the ports in several ways. A write hit taken as a miss drops cache_wr_o and blanks dq_oe_o on the following write pulse. A miss taken as a hit raises dq_oe_o while output enable is low. A lost refresh flag surfaces only at the row-enable rise, as a missing or extra code 3. An off-by-one in the blanking counter moves the first clock on which dq_oe_o returns high, so the bench samples dq_oe_o on the clocks on either side of that boundary.

// File: rtl/crd_pkg.sv
package crd_pkg;

  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_FETCH    = 3'd1,
    CMD_WRITE    = 3'd2,
    CMD_RFSH_ROW = 3'd3,
    CMD_RFSH_INT = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    CY_RD_HIT,
    CY_RD_MISS,
    CY_WR_HIT,
    CY_WR_MISS,
    CY_RFSH,
    CY_BAD
  } cycle_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WHIT,
    ST_WMISS,
    ST_RFSH
  } state_e;

  typedef struct packed {
    logic re_n;
    logic cl_n;
    logic we_n;
    logic rf_n;
    logic cs_n;
    logic oe_n;
    logic wr_mode;
  } strb_t;

  localparam int STRB_W = $bits(strb_t);
  // all strobes inactive, read mode
  localparam logic [STRB_W-1:0] STRB_IDLE = 7'b1111110;

endpackage

// File: rtl/crd_sync.sv
module crd_sync #(
  parameter int              W      = 1,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    RST    = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/crd_edge.sv
module crd_edge #(
  parameter int           W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prv_q <= RST;
    else         prv_q <= d_i;
  end

  assign rise_o = d_i & ~prv_q;

endmodule

// File: rtl/crd_decode.sv
module crd_decode
  import crd_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input  strb_t             s_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [ROW_W-1:0]  lrr_i,
  input  logic              lrr_vld_i,
  output cycle_e            cy_o
);

  logic hit;
  assign hit = lrr_vld_i && (row_i == lrr_i);

  always_comb begin
    if (!s_i.rf_n) begin
      cy_o = CY_RFSH;
    end else if (s_i.cs_n) begin
      cy_o = CY_BAD;
    end else if (!s_i.wr_mode) begin
      if (s_i.cl_n) cy_o = hit ? CY_RD_HIT : CY_RD_MISS;
      else          cy_o = CY_BAD;
    end else begin
      if (s_i.cl_n && s_i.we_n) cy_o = hit ? CY_WR_HIT : CY_WR_MISS;
      else                      cy_o = CY_BAD;
    end
  end

endmodule

// File: rtl/crd_blank.sv
module crd_blank #(
  parameter int DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             busy_o
);

  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= dly_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R9
  blank_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/crdram_ctrl.sv
module crdram_ctrl
  import crd_pkg::*;
#(
  parameter int ROW_W       = 11,
  parameter int COL_W       = 9,
  parameter int RCNT_W      = 10,
  parameter int DLY_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             row_en_ni,
  input  logic             col_lat_ni,
  input  logic             wr_en_ni,
  input  logic             rfsh_ni,
  input  logic             sel_ni,
  input  logic             oe_ni,
  input  logic             wr_mode_i,
  input  logic [ROW_W-1:0] addr_i,
  input  logic [DLY_W-1:0] blank_dly_i,
  input  logic             arr_ack_i,
  output logic [2:0]       arr_cmd_o,
  output logic [ROW_W-1:0] arr_row_o,
  output logic [COL_W-1:0] arr_col_o,
  output logic             cache_wr_o,
  output logic             dq_oe_o,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [COL_W-1:0] rd_col_o,
  output logic             err_o
);

  localparam int EDGE_W = 3;
  localparam logic [EDGE_W-1:0] EDGE_RST = 3'b010;

  logic [STRB_W-1:0] raw_vec, s_vec;
  strb_t             s;
  logic [ROW_W-1:0]  s_addr;
  logic [COL_W-1:0]  col;
  logic [EDGE_W-1:0] ev, er;
  logic              re_fall, re_rise, wr_edge;
  cycle_e            cy;

  state_e            st_q;
  logic [ROW_W-1:0]  lrr_q, cur_row_q, row_q;
  logic              lrr_vld_q, col_seen_q, pend_q, err_q, cwr_q;
  logic [RCNT_W-1:0] rcnt_q;
  cmd_e              cmd_q;
  logic [COL_W-1:0]  col_q;
  logic              blank_ld, blank_busy, blk;

  assign raw_vec = {row_en_ni, col_lat_ni, wr_en_ni, rfsh_ni, sel_ni, oe_ni, wr_mode_i};

  crd_sync #(.W(STRB_W), .STAGES(SYNC_STAGES), .RST(STRB_IDLE)) i_strb_sync (
    .clk_i, .rst_ni, .d_i(raw_vec), .q_o(s_vec)
  );

  crd_sync #(.W(ROW_W), .STAGES(SYNC_STAGES), .RST('0)) i_addr_sync (
    .clk_i, .rst_ni, .d_i(addr_i), .q_o(s_addr)
  );

  assign s   = strb_t'(s_vec);
  assign col = s_addr[COL_W-1:0];

  // bit2: row active, bit1: row idle, bit0: write strobes both low
  assign ev = {~s.re_n, s.re_n, ~s.cl_n & ~s.we_n};

  crd_edge #(.W(EDGE_W), .RST(EDGE_RST)) i_edge (
    .clk_i, .rst_ni, .d_i(ev), .rise_o(er)
  );

  assign re_fall = er[2];
  assign re_rise = er[1];
  assign wr_edge = er[0];

  crd_decode #(.ROW_W(ROW_W)) i_decode (
    .s_i(s), .row_i(s_addr), .lrr_i(lrr_q), .lrr_vld_i(lrr_vld_q), .cy_o(cy)
  );

  assign blank_ld = (st_q == ST_WMISS) && re_rise;

  crd_blank #(.DLY_W(DLY_W)) i_blank (
    .clk_i, .rst_ni, .load_i(blank_ld), .dly_i(blank_dly_i), .busy_o(blank_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      lrr_q      <= '0;
      lrr_vld_q  <= 1'b0;
      cur_row_q  <= '0;
      col_seen_q <= 1'b0;
      rcnt_q     <= '0;
      cmd_q      <= CMD_NONE;
      row_q      <= '0;
      col_q      <= '0;
      cwr_q      <= 1'b0;
      pend_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      cmd_q <= CMD_NONE;
      cwr_q <= 1'b0;
      if (arr_ack_i) pend_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (re_fall) begin
            unique case (cy)
              CY_RD_HIT, CY_RD_MISS: begin
                st_q      <= ST_READ;
                lrr_q     <= s_addr;
                lrr_vld_q <= 1'b1;
                if (cy == CY_RD_MISS) begin
                  cmd_q  <= CMD_FETCH;
                  row_q  <= s_addr;
                  pend_q <= 1'b1;
                end
              end
              CY_WR_HIT, CY_WR_MISS: begin
                st_q       <= (cy == CY_WR_HIT) ? ST_WHIT : ST_WMISS;
                cur_row_q  <= s_addr;
                col_seen_q <= 1'b0;
              end
              CY_RFSH: begin
                st_q   <= ST_RFSH;
                cmd_q  <= CMD_RFSH_INT;
                row_q  <= ROW_W'(rcnt_q);
                rcnt_q <= rcnt_q + 1'b1;
              end
              default: err_q <= 1'b1;
            endcase
          end
        end
        ST_READ, ST_RFSH: begin
          if (re_rise) st_q <= ST_IDLE;
        end
        ST_WHIT, ST_WMISS: begin
          if (!s.cl_n) col_seen_q <= 1'b1;
          if (re_rise) begin
            st_q <= ST_IDLE;
            // no column strobe seen: acts as refresh of the addressed row
            if (!col_seen_q && s.cl_n) begin
              cmd_q <= CMD_RFSH_ROW;
              row_q <= cur_row_q;
            end
          end else if (wr_edge) begin
            cmd_q <= CMD_WRITE;
            row_q <= cur_row_q;
            col_q <= col;
            cwr_q <= (st_q == ST_WHIT);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign blk = pend_q || blank_busy || (st_q == ST_WMISS) ||
               ((st_q == ST_WHIT) && !s.we_n);

  assign dq_oe_o    = !s.cs_n && !s.oe_n && !blk;
  assign arr_cmd_o  = cmd_q;
  assign arr_row_o  = row_q;
  assign arr_col_o  = col_q;
  assign cache_wr_o = cwr_q;
  assign rd_row_o   = lrr_q;
  assign rd_col_o   = col;
  assign err_o      = err_q;

  // R12
  bad_no_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && re_fall && cy == CY_BAD) |=> (arr_cmd_o == CMD_NONE && err_o));

  // R5
  cache_wr_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_wr_o |-> (arr_cmd_o == CMD_WRITE));

  // R4
  lrr_only_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrr_q) |-> (arr_cmd_o == CMD_FETCH));

  // R9
  wmiss_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WMISS) |-> !dq_oe_o);

  // R10
  rcnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_cmd_o == CMD_RFSH_INT) |-> (rcnt_q == RCNT_W'(arr_row_o) + 1'b1));

endmodule

// File: tb/test_crdram_ctrl.sv
`timescale 1ns/1ps
module test_crdram_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        re_n = 1'b1, cl_n = 1'b1, we_n = 1'b1, rf_n = 1'b1, cs_n = 1'b1, oe_n = 1'b1, md = 1'b0;
  logic [10:0] addr = '0;
  logic [3:0]  blank_dly = 4'd2;
  logic        auto_ack = 1'b1, auto_pulse = 1'b0, man_ack = 1'b0, ack;
  logic [2:0]  arr_cmd;
  logic [10:0] arr_row, rd_row;
  logic [8:0]  arr_col, rd_col;
  logic        cache_wr, dq_oe, err;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  assign ack = auto_pulse | man_ack;

  always @(negedge clk) auto_pulse <= auto_ack && (arr_cmd == 3'd1);

  crdram_ctrl i_crdram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .row_en_ni(re_n), .col_lat_ni(cl_n), .wr_en_ni(we_n),
    .rfsh_ni(rf_n), .sel_ni(cs_n), .oe_ni(oe_n), .wr_mode_i(md), .addr_i(addr),
    .blank_dly_i(blank_dly), .arr_ack_i(ack), .arr_cmd_o(arr_cmd), .arr_row_o(arr_row),
    .arr_col_o(arr_col), .cache_wr_o(cache_wr), .dq_oe_o(dq_oe), .rd_row_o(rd_row),
    .rd_col_o(rd_col), .err_o(err)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        re, cl, we, rf, cs, oe, md;
    logic [10:0] addr;
    logic [2:0]  cmd;
    logic [10:0] row;
    logic [8:0]  col;
    logic        cwr, doe, err;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{1,  1,1,1,1,1,1,0,  0, 0,  0, 0, 0,0,0},  // R1 idle after reset
    '{4,  0,1,1,1,0,1,0,  5, 1,  5, 0, 0,0,0},  // R4 first read misses
    '{4,  0,1,1,1,0,0,0,  7, 0,  5, 0, 0,1,0},  // R4 read allowed after ack
    '{11, 1,1,1,1,0,0,0,  3, 0,  5, 0, 0,1,0},  // R11 row idle cache read
    '{3,  0,1,1,1,0,0,0,  5, 0,  5, 0, 0,1,0},  // R3 read hit
    '{3,  1,1,1,1,0,1,0,  5, 0,  5, 0, 0,0,0},  // R3
    '{8,  0,1,1,1,0,0,1,  5, 0,  5, 0, 0,1,0},  // R8 write hit, we high
    '{5,  0,0,0,1,0,0,1,  9, 2,  5, 9, 1,0,0},  // R5 write hit pulse
    '{8,  0,1,1,1,0,0,1,  9, 0,  5, 0, 0,1,0},  // R8
    '{5,  1,1,1,1,0,1,0,  9, 0,  5, 0, 0,0,0},  // R5 end, no refresh
    '{9,  0,1,1,1,0,0,1, 12, 0,  5, 0, 0,0,0},  // R9 write miss blanks
    '{6,  0,0,0,1,0,0,1,  4, 2, 12, 4, 0,0,0},  // R6 array only
    '{6,  0,1,1,1,0,0,1,  4, 0,  5, 0, 0,0,0},  // R6 stored row kept
    '{9,  1,1,1,1,0,0,0,  4, 0,  5, 0, 0,0,0},  // R9 blank after rise
    '{9,  1,1,1,1,0,0,0,  4, 0,  5, 0, 0,1,0},  // R9 blank over
    '{7,  0,1,1,1,0,1,1, 20, 0,  5, 0, 0,0,0},  // R7 write, no column
    '{7,  1,1,1,1,0,1,1, 20, 3, 20, 0, 0,0,0},  // R7 addressed refresh
    '{7,  1,1,1,1,0,0,0, 20, 0,  5, 0, 0,1,0},  // R7 stored row kept
    '{10, 0,1,1,0,1,1,0,  0, 4,  0, 0, 0,0,0},  // R10 deselected refresh
    '{10, 1,1,1,1,1,1,0,  0, 0,  5, 0, 0,0,0},  // R10
    '{10, 0,1,1,0,0,0,0,  0, 4,  1, 0, 0,1,0},  // R10 counter steps, read ok
    '{10, 1,1,1,1,0,1,0,  0, 0,  5, 0, 0,0,0},  // R10
    '{4,  0,1,1,1,0,1,0,  6, 1,  6, 0, 0,0,0},  // R4 new row
    '{4,  1,1,1,1,0,1,0,  6, 0,  6, 0, 0,0,0},  // R4 stored row loaded
    '{12, 0,1,1,1,1,1,0,  6, 0,  6, 0, 0,0,1},  // R12 deselected read
    '{12, 1,1,1,1,1,1,0,  6, 0,  6, 0, 0,0,1},  // R12 sticky
    '{12, 0,0,1,1,0,1,0,  6, 0,  6, 0, 0,0,1}   // R12 read with column low
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic re, cl, we, rf, cs, oe, m, input logic [10:0] a);
    re_n = re; cl_n = cl; we_n = we; rf_n = rf; cs_n = cs; oe_n = oe; md = m; addr = a;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drive(1,1,1,1,1,1,0,11'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R2: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) begin
      string tag;
      drive(TBL[i].re, TBL[i].cl, TBL[i].we, TBL[i].rf, TBL[i].cs, TBL[i].oe, TBL[i].md, TBL[i].addr);
      step(3);
      tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
      chk({tag, " cmd"}, arr_cmd, TBL[i].cmd);
      if (TBL[i].cmd != 3'd0) chk({tag, " arr_row"}, arr_row, TBL[i].row);
      else                    chk({tag, " rd_row"}, rd_row, TBL[i].row);
      if (TBL[i].cmd == 3'd2) chk({tag, " arr_col"}, arr_col, TBL[i].col);
      if (TBL[i].cmd == 3'd0 && TBL[i].doe) chk({tag, " rd_col"}, rd_col, int'(TBL[i].addr[8:0]));
      chk({tag, " cache_wr"}, cache_wr, TBL[i].cwr);
      chk({tag, " dq_oe"}, dq_oe, TBL[i].doe);
      chk({tag, " err"}, err, TBL[i].err);
    end

    // R1: reset clears the sticky flag and outputs
    do_reset();
    chk("R1 cmd", arr_cmd, 0);
    chk("R1 cache_wr", cache_wr, 0);
    chk("R1 err", err, 0);
    chk("R1 dq_oe", dq_oe, 0);

    // R2: command lands on the third edge and lasts one cycle
    drive(0,1,1,1,0,1,0,11'd33);
    step(2);
    chk("R2 early", arr_cmd, 0);
    step(1);
    chk("R2 on time", arr_cmd, 1);
    chk("R2 row", arr_row, 33);
    step(1);
    chk("R2 one cycle", arr_cmd, 0);
    drive(1,1,1,1,0,1,0,11'd33);
    step(3);

    // R12: write started with write enable low
    do_reset();
    drive(0,1,0,1,0,1,1,11'd8);
    step(3);
    chk("R12 wr start cmd", arr_cmd, 0);
    chk("R12 wr start err", err, 1);
    drive(1,1,1,1,0,1,0,11'd8);
    step(3);
    drive(0,1,1,1,0,1,0,11'd9);
    step(3);
    chk("R12 sticky", err, 1);
    drive(1,1,1,1,0,1,0,11'd9);
    step(3);

    // R9: blanking boundary with a longer delay
    do_reset();
    blank_dly = 4'd3;
    drive(0,1,1,1,0,0,1,11'd40);
    step(3);
    chk("R9 wmiss oe", dq_oe, 0);
    drive(0,0,0,1,0,0,1,11'd2);
    step(3);
    chk("R9 wmiss write", arr_cmd, 2);
    chk("R6 wmiss no cache", cache_wr, 0);
    drive(0,1,1,1,0,0,1,11'd2);
    step(3);
    drive(1,1,1,1,0,0,0,11'd2);
    step(3);
    chk("R9 blank t0", dq_oe, 0);
    step(2);
    chk("R9 blank last", dq_oe, 0);
    step(1);
    chk("R9 blank done", dq_oe, 1);
    blank_dly = 4'd2;

    // R4: reads held off until the fetch is acknowledged
    auto_ack = 1'b0;
    do_reset();
    drive(0,1,1,1,0,0,0,11'd50);
    step(3);
    chk("R4 fetch", arr_cmd, 1);
    chk("R4 blocked", dq_oe, 0);
    step(3);
    chk("R4 still blocked", dq_oe, 0);
    man_ack = 1'b1;
    step(1);
    man_ack = 1'b0;
    chk("R4 released", dq_oe, 1);
    chk("R4 stored row", rd_row, 50);
    auto_ack = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule